// File: doc/BRIEF.md
# Configurable Parallel-Prefix Binary Adder

This block adds two N-bit operands and a carry-in. It produces an N-bit sum and a carry-out. Every carry comes from a log-depth prefix network of generate/propagate combining cells, not from a rippling chain. The carry-in takes the lowest slot of the network as a pure generate term with a propagate of zero. Because of this, each cell whose span reaches that slot only needs to produce a generate value. Those cells use a reduced form of the combining cell.

A parameter picks how the network is wired, from three options:
- **Dense:** every position combines with the one a power of two below it at each level. Fanout stays at two, and it takes log2(N) levels.
- **Split:** each block doubles per level, and the upper half of each block borrows the prefix of the lower half. It takes log2(N) levels and has wide fanout.
- **Sweep:** an up-sweep builds power-of-two spans and a down-sweep fills in the gaps. It takes 2·log2(N)−1 levels and has the fewest cells.

The result is captured in one output register stage, so the sum and carry appear one clock after the operands. The register clears on an asynchronous active-low reset.

Top module: `ppa_adder`

## Requirements
- R1: One clock edge after the operands are sampled (with reset deasserted at that edge), `sum_o` equals the low N bits of `a_i + b_i + cin_i`.
- R2: In that same cycle, `cout_o` equals bit N of `a_i + b_i + cin_i`.
- R3: While `rst_ni` is low, `sum_o` and `cout_o` are zero, immediately on assertion and regardless of the operands.
- R4: With both operands zero, the sum is `cin_i` in bit 0 and `cout_o` is 0.
- R5: When `a_i ^ b_i` is all ones, a carry-in of 1 gives an all-zero sum and `cout_o = 1`. A carry-in of 0 gives an all-ones sum and `cout_o = 0`.
- R6: When both operand MSBs are 1, `cout_o` is 1 whatever the other bits.
- R7: `TOPOLOGY` encodes 0 = dense, 1 = split, 2 = sweep. All three give bit-identical sums and carries for N = 4, 16 and 32.
- R8: The outputs change only at a rising clock edge. A change of operands between edges leaves them holding the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Registered sum |
| cout_o | output | 1 | Registered carry out of bit N−1 |

## Verification
The bench targets carries that must cross the full width. These come from alternating patterns with complementary bits, and from an all-ones operand plus one. A network with a missing or misplaced cell gives a wrong upper sum bit or a lost carry-out on exactly these patterns. A gray cell placed where the span does not yet reach bit 0 silently drops the carry-in. The bench exposes this with zero operands plus a carry-in, and with full-propagate words. Exhaustive 4-bit sweeps and random 16- and 32-bit runs compare all three wirings against each other and against arithmetic. This catches a wrong partner index in any one topology. Mid-run reset and between-edge operand changes show whether the result register clears and holds as required.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
    typedef enum logic [1:0] {
        TOPO_DENSE = 2'd0,
        TOPO_SPLIT = 2'd1,
        TOPO_SWEEP = 2'd2
    } topo_e;
endpackage

// File: rtl/ppa_bitpg.sv
module ppa_bitpg #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] g_o,
    output logic [N-1:0] p_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign g_o[i] = a_i[i] & b_i[i];
        assign p_o[i] = a_i[i] ^ b_i[i];
    end
endmodule

// File: rtl/ppa_black.sv
module ppa_black (
    input  logic g_hi_i,
    input  logic p_hi_i,
    input  logic g_lo_i,
    input  logic p_lo_i,
    output logic g_o,
    output logic p_o
);
    assign g_o = g_hi_i | (p_hi_i & g_lo_i);
    assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/ppa_gray.sv
module ppa_gray (
    input  logic g_hi_i,
    input  logic p_hi_i,
    input  logic g_lo_i,
    output logic g_o
);
    assign g_o = g_hi_i | (p_hi_i & g_lo_i);
endmodule

// File: rtl/ppa_prefix.sv
module ppa_prefix
    import ppa_pkg::*;
#(
    parameter int    N        = 16,
    parameter topo_e TOPOLOGY = TOPO_DENSE
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] gpre_o
);
    localparam int LOG = $clog2(N);
    localparam int NL  = (TOPOLOGY == TOPO_SWEEP) ? 2 * LOG - 1 : LOG;

    // Lower partner of a position at a level, or -1 when it is only buffered.
    function automatic int partner(int lvl, int pos);
        int d;
        partner = -1;
        case (TOPOLOGY)
            TOPO_DENSE: begin
                d = 1 << lvl;
                if (pos >= d) partner = pos - d;
            end
            TOPO_SPLIT: begin
                if (((pos >> lvl) & 1) == 1) partner = ((pos >> lvl) << lvl) - 1;
            end
            default: begin
                if (lvl < LOG) begin
                    d = 1 << lvl;
                    if (((pos + 1) % (2 * d)) == 0) partner = pos - d;
                end else begin
                    d = 1 << (2 * LOG - 2 - lvl);
                    if (pos >= 2 * d && ((pos + 1) % (2 * d)) == d) partner = pos - d;
                end
            end
        endcase
    endfunction

    // Lowest position covered by a position's span after a number of levels.
    function automatic int span_low(int lvl, int pos);
        int q;
        if (lvl == 0) return pos;
        q = partner(lvl - 1, pos);
        if (q < 0) return span_low(lvl - 1, pos);
        return span_low(lvl - 1, q);
    endfunction

    logic gl [0:NL][0:N-1];
    logic pl [0:NL-1][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign gl[0][i] = g_i[i];
        assign pl[0][i] = p_i[i];
        assign gpre_o[i] = gl[NL][i];
    end

    for (genvar lv = 0; lv < NL; lv++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_pos
            localparam int Q    = partner(lv, i);
            localparam bit GRAY = (Q >= 0) && ((span_low(lv, Q) == 0) || (lv == NL - 1));
            if (Q < 0) begin : g_buf
                assign gl[lv+1][i] = gl[lv][i];
                if (lv + 1 < NL) begin : g_pbuf
                    assign pl[lv+1][i] = pl[lv][i];
                end
            end else if (GRAY) begin : g_gray
                ppa_gray u_cell (
                    .g_hi_i (gl[lv][i]),
                    .p_hi_i (pl[lv][i]),
                    .g_lo_i (gl[lv][Q]),
                    .g_o    (gl[lv+1][i])
                );
                if (lv + 1 < NL) begin : g_pzero
                    assign pl[lv+1][i] = 1'b0;
                end
            end else begin : g_black
                ppa_black u_cell (
                    .g_hi_i (gl[lv][i]),
                    .p_hi_i (pl[lv][i]),
                    .g_lo_i (gl[lv][Q]),
                    .p_lo_i (pl[lv][Q]),
                    .g_o    (gl[lv+1][i]),
                    .p_o    (pl[lv+1][i])
                );
            end
        end
    end
endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
    import ppa_pkg::*;
#(
    parameter int    N        = 16,
    parameter topo_e TOPOLOGY = TOPO_DENSE
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    typedef struct packed {
        logic [N-1:0] sum;
        logic         cout;
    } res_t;

    logic [N-1:0] bit_g, bit_p;
    logic [N-1:0] net_g, net_p;
    logic [N-1:0] carry;
    logic         cout_full;
    res_t         res_d, res_q;

    ppa_bitpg #(.N(N)) u_bitpg (
        .a_i (a_i),
        .b_i (b_i),
        .g_o (bit_g),
        .p_o (bit_p)
    );

    // Slot 0 holds the carry-in; slot k holds operand bit k-1.
    if (N > 1) begin : g_shift
        assign net_g = {bit_g[N-2:0], cin_i};
        assign net_p = {bit_p[N-2:0], 1'b0};
    end else begin : g_single
        assign net_g = cin_i;
        assign net_p = 1'b0;
    end

    ppa_prefix #(.N(N), .TOPOLOGY(TOPOLOGY)) u_prefix (
        .g_i    (net_g),
        .p_i    (net_p),
        .gpre_o (carry)
    );

    // Final span covering the top operand bit down to the carry-in.
    ppa_gray u_cout (
        .g_hi_i (bit_g[N-1]),
        .p_hi_i (bit_p[N-1]),
        .g_lo_i (carry[N-1]),
        .g_o    (cout_full)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = bit_p ^ carry;
        res_d.cout = cout_full;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;
endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk #(
    parameter int N = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o
);
    localparam int W = N + 1;

    AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> {cout_o, sum_o} == (W'($past(a_i)) + W'($past(b_i)) + W'($past(cin_i)))); // R1 R2

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        !rst_ni |-> (sum_o == '0 && !cout_o)); // R3

    AST_CIN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(a_i) == '0 && $past(b_i) == '0) |-> (sum_o == N'($past(cin_i)) && !cout_o)); // R4

    AST_FULL_PROPAGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(a_i) ^ $past(b_i)) == '1)
        |-> (cout_o == $past(cin_i) && sum_o == {N{!$past(cin_i)}})); // R5

    AST_TOP_GENERATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(a_i[N-1]) && $past(b_i[N-1])) |-> cout_o); // R6
endmodule

bind ppa_adder ppa_adder_chk #(.N(N)) u_chk (.*);

// File: tb/ppa_adder_test.sv
module ppa_adder_test;
    import ppa_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [31:0] a = '0, b = '0;
    logic        cin = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    logic [3:0]  s4 [3];  logic c4 [3];
    logic [15:0] s16 [3]; logic c16 [3];
    logic [31:0] s32 [3]; logic c32 [3];

    ppa_adder #(.N(16), .TOPOLOGY(TOPO_DENSE)) uut (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin),
        .sum_o(s16[0]), .cout_o(c16[0]));

    for (genvar t = 0; t < 3; t++) begin : g_dut
        if (t > 0) begin : g_w16
            ppa_adder #(.N(16), .TOPOLOGY(topo_e'(t))) u16 (
                .clk_i(clk), .rst_ni(rst_n), .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin),
                .sum_o(s16[t]), .cout_o(c16[t]));
        end
        ppa_adder #(.N(4), .TOPOLOGY(topo_e'(t))) u4 (
            .clk_i(clk), .rst_ni(rst_n), .a_i(a[3:0]), .b_i(b[3:0]), .cin_i(cin),
            .sum_o(s4[t]), .cout_o(c4[t]));
        ppa_adder #(.N(32), .TOPOLOGY(topo_e'(t))) u32 (
            .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
            .sum_o(s32[t]), .cout_o(c32[t]));
    end

    // {a, b, cin, expected sum, expected cout}
    localparam int NV = 12;
    localparam logic [49:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0}, // R4 carry-in alone
        {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R5 propagate, cin 1
        {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0}, // R5 propagate, cin 0
        {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1}, // R5
        {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1}, // R6 top generate
        {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1}, // R6
        {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
        {16'h00FF, 16'h0F01, 1'b0, 16'h1000, 1'b0},
        {16'h8001, 16'h7FFF, 1'b0, 16'h0000, 1'b1}
    };

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [32:0] e4, e16, e32;
        e4  = 33'(a[3:0]) + 33'(b[3:0]) + 33'(cin);
        e16 = 33'(a[15:0]) + 33'(b[15:0]) + 33'(cin);
        e32 = 33'(a) + 33'(b) + 33'(cin);
        for (int t = 0; t < 3; t++) begin
            check($sformatf("%s n4 topo%0d", tag, t), 33'({c4[t], s4[t]}), e4);
            check($sformatf("%s n16 topo%0d", tag, t), 33'({c16[t], s16[t]}), e16);
            check($sformatf("%s n32 topo%0d", tag, t), {c32[t], s32[t]}, e32);
        end
    endtask

    task automatic check_zero(input string tag);
        for (int t = 0; t < 3; t++) begin
            check($sformatf("%s n4 topo%0d", tag, t), 33'({c4[t], s4[t]}), '0);
            check($sformatf("%s n16 topo%0d", tag, t), 33'({c16[t], s16[t]}), '0);
            check($sformatf("%s n32 topo%0d", tag, t), {c32[t], s32[t]}, '0);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        check_zero("R3 initial reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table: R1 R2 R4 R5 R6 on the 16-bit wirings, R7 by running all three.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            a   = {16'h0, VEC[k][49:34]};
            b   = {16'h0, VEC[k][33:18]};
            cin = VEC[k][17];
            @(negedge clk);
            for (int t = 0; t < 3; t++)
                check($sformatf("R1 R2 R7 vector %0d topo%0d", k, t),
                      33'({c16[t], s16[t]}), 33'({VEC[k][0], VEC[k][16:1]}));
        end

        // R8: between-edge operand change must not reach the outputs.
        @(negedge clk);
        a = 32'd1; b = 32'd1; cin = 1'b0;
        @(negedge clk);
        check_all("R1 latency base");
        a = 32'd3; b = 32'd4; cin = 1'b1;
        #2;
        check("R8 hold between edges", 33'({c16[0], s16[0]}), 33'd2);
        check("R8 hold between edges n32", {c32[2], s32[2]}, 33'd2);
        @(negedge clk);
        check_all("R8 after edge");

        // Exhaustive 4-bit: R7 all wirings agree with arithmetic.
        for (int x = 0; x < 512; x++) begin
            a   = {$urandom(), 4'(x >> 5)};
            b   = {$urandom(), 4'(x >> 1)};
            cin = x[0];
            @(negedge clk);
            check_all("R7 exhaustive");
        end

        // Random wide operands with some forced corner shapes: R1 R2 R5 R6.
        for (int r = 0; r < 1500; r++) begin
            a   = $urandom();
            b   = $urandom();
            cin = 1'($urandom());
            if (r % 7 == 0) b = ~a;
            if (r % 11 == 0) begin a[31] = 1'b1; b[31] = 1'b1; a[15] = 1'b1; b[15] = 1'b1; end
            @(negedge clk);
            check_all("R1 R2 random");
        end

        // R3: reset mid-run clears immediately and holds against operands.
        a = 32'hFFFF_FFFF; b = 32'h1; cin = 1'b1;
        @(negedge clk);
        check_all("R2 before reset");
        rst_n = 1'b0;
        #1;
        check_zero("R3 async clear");
        @(negedge clk);
        check_zero("R3 held in reset");
        rst_n = 1'b1;
        a = 32'h0; b = 32'h0; cin = 1'b1;
        @(negedge clk);
        check_all("R4 after reset release");

        summary();
    end
endmodule